// File: doc/BRIEF.md
# Integer ALU with Condition Flags

This block is the integer execution unit of a 32-bit core. It takes one operation at a time: an opcode, a source operand, a destination operand and a size selector (byte, word or long). It returns the new destination value, a write-enable bit, and a five-flag condition register. The flag register lives inside the block. Each opcode has its own rule for which flags change and how. The extend, or carry-chained, operations read the stored extend flag. This lets software build wider arithmetic from a chain of 32-bit steps.

Operations enter on a valid/ready stream and leave on a second one. The input is taken on a clock edge where `in_valid` and `in_ready` are both high. The result appears on the output stream on the next edge. The output holds its value and its valid bit until `out_ready` is high. While a result is held back, `in_ready` is low, so the block takes nothing new. A new operation may be taken on the same edge that drains the old result. The flags change only on an edge that takes an operation.

For byte and word sizes, only the low 8 or 16 bits of the destination are computed. The upper bits of the destination pass through unchanged.

Top module: `int_alu_cc`

## Requirements
- R1: While reset is active, `out_valid` is 0 and all five flags are 0.
- R2: `in_ready` equals `!out_valid || out_ready`. A result appears on the edge after its operation is taken. It stays unchanged while `out_valid` is high and `out_ready` is low.
- R3: Add (opcode 0) and subtract (opcode 1, destination minus source) work at the size given by `in_size`: 00 byte, 01 word, 10 or 11 long. They set N to the top bit at that size, Z to "sized result is zero", V to signed overflow, and both C and X to the carry or borrow. Destination bits above the size are kept. The flag vector is {X,N,Z,V,C}, with X at bit 4 and C at bit 0.
- R4: Add-with-extend (2) computes source + destination + X. Subtract-with-extend (3) computes destination − source − X. Both set X, N, V and C as in R3. Z is cleared when the sized result is nonzero and is otherwise left unchanged.
- R5: Negate (4) computes 0 − destination. Negate-with-extend (5) computes 0 − destination − X, and updates Z as in R4. All other flags follow R3.
- R6: AND (6), OR (7), XOR (8), NOT of the destination (9) and test (12) set N and Z from the sized result. They force V and C to 0 and keep X. Test writes nothing. Move-quick (20) writes source bits 7:0 sign-extended to 32 bits and follows the same flag rule at long size.
- R7: Clear (10) zeroes the sized part of the destination and sets N=0, Z=1, V=0 and C=0. X is kept.
- R8: Compare (11) sets N, Z, V and C from destination − source at the given size. It keeps X, drives `out_wr` low and returns the destination unchanged.
- R9: Sign extension takes the destination in three forms: byte to word (13), word to long (14) and byte to long (15). The size input is ignored. N and Z are taken at the target width, V and C are cleared, and X is kept.
- R10: Swap (16) exchanges destination bits 31:16 and 15:0. N and Z are taken from the 32-bit result, V and C are cleared, and X is kept.
- R11: Address add (18) and address subtract (19) compute destination ± source over all 32 bits, whatever the size. They write the result and leave all five flags unchanged.
- R12: Flag load (17) copies source bits 4:0 into {X,N,Z,V,C}. It drives `out_wr` low and returns the destination.
- R13: The flags change only on an edge where an operation is taken. Between operations they hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The block can take an operation |
| in_op | input | 5 | Opcode |
| in_size | input | 2 | Operand size: 00 byte, 01 word, otherwise long |
| in_src | input | 32 | Source operand |
| in_dst | input | 32 | Destination operand |
| out_valid | output | 1 | A result is offered |
| out_ready | input | 1 | The consumer takes the result |
| out_result | output | 32 | New destination value |
| out_wr | output | 1 | The result is to be written back |
| cc_flags | output | 5 | Condition flags {X,N,Z,V,C} |

## Verification
Each result and its flags are due one clock edge after the operation is taken. They stay due until the edge on which the consumer accepts them. The scoreboard works out each expected item in the cycle the input is taken, using a separate wide-integer model. It compares the item only on a falling edge where the output handshake is about to complete, so a stalled result is never compared early. On every stalled cycle the bench also checks that `in_ready` is low. `out_ready` follows a fixed pattern, so results wait for various numbers of cycles.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

  typedef enum logic [4:0] {
    OP_ADD   = 5'd0,
    OP_SUB   = 5'd1,
    OP_ADDX  = 5'd2,
    OP_SUBX  = 5'd3,
    OP_NEG   = 5'd4,
    OP_NEGX  = 5'd5,
    OP_AND   = 5'd6,
    OP_OR    = 5'd7,
    OP_XOR   = 5'd8,
    OP_NOT   = 5'd9,
    OP_CLR   = 5'd10,
    OP_CMP   = 5'd11,
    OP_TST   = 5'd12,
    OP_EXTBW = 5'd13,
    OP_EXTWL = 5'd14,
    OP_EXTBL = 5'd15,
    OP_SWAP  = 5'd16,
    OP_LDCC  = 5'd17,
    OP_ADDA  = 5'd18,
    OP_SUBA  = 5'd19,
    OP_MOVQ  = 5'd20
  } alu_op_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10
  } alu_size_e;

  // how the flag register reacts to an accepted operation
  typedef enum logic [2:0] {
    FC_NONE,
    FC_ARITH,
    FC_CHAIN,
    FC_LOGIC,
    FC_CLEAR,
    FC_CMP,
    FC_LOAD
  } flag_cls_e;

  localparam int FLAG_W = 5;
  localparam int FX = 4;
  localparam int FN = 3;
  localparam int FZ = 2;
  localparam int FV = 1;
  localparam int FC = 0;

endpackage

// File: rtl/int_alu_addsub.sv
// Adder/subtractor that aligns the sized operand to the top of the word,
// so carry, borrow and overflow fall out at a fixed bit for every size.
module int_alu_addsub #(
  parameter int W = 32,
  localparam int SHW = $clog2(W)
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           cin,
  input  logic           sub,
  input  logic [SHW-1:0] sh,
  output logic [W-1:0]   res,
  output logic           cout,
  output logic           ovf
);
  logic [W-1:0] a_al, b_al, r_al;
  logic [W:0]   cin_al, sum;

  always_comb begin
    a_al   = a << sh;
    b_al   = b << sh;
    cin_al = {{W{1'b0}}, cin} << sh;
    if (sub) sum = {1'b0, a_al} - {1'b0, b_al} - cin_al;
    else     sum = {1'b0, a_al} + {1'b0, b_al} + cin_al;
    r_al = sum[W-1:0];
    cout = sum[W];
    if (sub) ovf = (a_al[W-1] ^ b_al[W-1]) & (a_al[W-1] ^ r_al[W-1]);
    else     ovf = ~(a_al[W-1] ^ b_al[W-1]) & (a_al[W-1] ^ r_al[W-1]);
    res = r_al >> sh;
  end
endmodule

// File: rtl/int_alu_unary.sv
// Bitwise, extension, swap and move-quick datapath.
module int_alu_unary
  import int_alu_pkg::*;
#(
  parameter int W = 32,
  localparam int HW = W / 2
) (
  input  alu_op_e       op,
  input  logic [W-1:0]  src,
  input  logic [W-1:0]  dst,
  output logic [W-1:0]  res
);
  always_comb begin
    res = dst;
    case (op)
      OP_AND:   res = dst & src;
      OP_OR:    res = dst | src;
      OP_XOR:   res = dst ^ src;
      OP_NOT:   res = ~dst;
      OP_CLR:   res = '0;
      OP_TST:   res = dst;
      OP_EXTBW: res = {dst[W-1:16], {8{dst[7]}}, dst[7:0]};
      OP_EXTWL: res = {{(W-16){dst[15]}}, dst[15:0]};
      OP_EXTBL: res = {{(W-8){dst[7]}}, dst[7:0]};
      OP_SWAP:  res = {dst[HW-1:0], dst[W-1:HW]};
      OP_MOVQ:  res = {{(W-8){src[7]}}, src[7:0]};
      default:  res = dst;
    endcase
  end
endmodule

// File: rtl/int_alu_ccr.sv
// Condition flag register with per-class update rules.
module int_alu_ccr
  import int_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  flag_cls_e         cls,
  input  logic              r_n,
  input  logic              r_z,
  input  logic              r_v,
  input  logic              r_c,
  input  logic [FLAG_W-1:0] ld_val,
  output logic [FLAG_W-1:0] q
);
  logic [FLAG_W-1:0] nxt;

  always_comb begin
    nxt = q;
    case (cls)
      FC_ARITH: begin
        nxt[FX] = r_c; nxt[FN] = r_n; nxt[FZ] = r_z; nxt[FV] = r_v; nxt[FC] = r_c;
      end
      FC_CHAIN: begin
        nxt[FX] = r_c; nxt[FN] = r_n; nxt[FZ] = q[FZ] & r_z; nxt[FV] = r_v; nxt[FC] = r_c;
      end
      FC_LOGIC: begin
        nxt[FN] = r_n; nxt[FZ] = r_z; nxt[FV] = 1'b0; nxt[FC] = 1'b0;
      end
      FC_CLEAR: begin
        nxt[FN] = 1'b0; nxt[FZ] = 1'b1; nxt[FV] = 1'b0; nxt[FC] = 1'b0;
      end
      FC_CMP: begin
        nxt[FN] = r_n; nxt[FZ] = r_z; nxt[FV] = r_v; nxt[FC] = r_c;
      end
      FC_LOAD: nxt = ld_val;
      default: nxt = q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   q <= '0;
    else if (upd) q <= nxt;
  end
endmodule

// File: rtl/int_alu_cc.sv
module int_alu_cc
  import int_alu_pkg::*;
#(
  parameter int W = 32,
  localparam int SHW = $clog2(W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [4:0]        in_op,
  input  logic [1:0]        in_size,
  input  logic [W-1:0]      in_src,
  input  logic [W-1:0]      in_dst,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [W-1:0]      out_result,
  output logic              out_wr,
  output logic [FLAG_W-1:0] cc_flags
);
  alu_op_e     op;
  alu_size_e   eff_sz;
  flag_cls_e   fcls;
  logic        use_arith, use_x, sub, wr;
  logic [W-1:0] a_sel, b_sel;
  logic [SHW-1:0] sh;
  logic [W-1:0] mask, ar_res, un_res, raw, aligned, merged;
  logic        ar_c, ar_v, r_n, r_z, take;

  // decode
  always_comb begin
    op        = alu_op_e'(in_op);
    eff_sz    = (in_size == 2'b11) ? SZ_LONG : alu_size_e'(in_size);
    a_sel     = in_dst;
    b_sel     = in_src;
    use_arith = 1'b0;
    use_x     = 1'b0;
    sub       = 1'b0;
    wr        = 1'b0;
    fcls      = FC_NONE;
    case (op)
      OP_ADD:  begin use_arith = 1'b1; wr = 1'b1; fcls = FC_ARITH; end
      OP_SUB:  begin use_arith = 1'b1; sub = 1'b1; wr = 1'b1; fcls = FC_ARITH; end
      OP_ADDX: begin use_arith = 1'b1; use_x = 1'b1; wr = 1'b1; fcls = FC_CHAIN; end
      OP_SUBX: begin use_arith = 1'b1; use_x = 1'b1; sub = 1'b1; wr = 1'b1; fcls = FC_CHAIN; end
      OP_NEG:  begin
        use_arith = 1'b1; sub = 1'b1; wr = 1'b1; fcls = FC_ARITH;
        a_sel = '0; b_sel = in_dst;
      end
      OP_NEGX: begin
        use_arith = 1'b1; use_x = 1'b1; sub = 1'b1; wr = 1'b1; fcls = FC_CHAIN;
        a_sel = '0; b_sel = in_dst;
      end
      OP_CMP:  begin use_arith = 1'b1; sub = 1'b1; fcls = FC_CMP; end
      OP_AND, OP_OR, OP_XOR, OP_NOT: begin wr = 1'b1; fcls = FC_LOGIC; end
      OP_TST:  fcls = FC_LOGIC;
      OP_CLR:  begin wr = 1'b1; fcls = FC_CLEAR; end
      OP_EXTBW: begin wr = 1'b1; fcls = FC_LOGIC; eff_sz = SZ_WORD; end
      OP_EXTWL, OP_EXTBL, OP_SWAP, OP_MOVQ: begin
        wr = 1'b1; fcls = FC_LOGIC; eff_sz = SZ_LONG;
      end
      OP_ADDA: begin use_arith = 1'b1; wr = 1'b1; eff_sz = SZ_LONG; end
      OP_SUBA: begin use_arith = 1'b1; sub = 1'b1; wr = 1'b1; eff_sz = SZ_LONG; end
      OP_LDCC: fcls = FC_LOAD;
      default: fcls = FC_NONE;
    endcase
  end

  // size to alignment shift and write mask
  always_comb begin
    case (eff_sz)
      SZ_BYTE: sh = SHW'(W - 8);
      SZ_WORD: sh = SHW'(W - 16);
      default: sh = '0;
    endcase
    mask = {W{1'b1}} >> sh;
  end

  int_alu_addsub #(.W(W)) u_addsub (
    .a    (a_sel),
    .b    (b_sel),
    .cin  (use_x & cc_flags[FX]),
    .sub  (sub),
    .sh   (sh),
    .res  (ar_res),
    .cout (ar_c),
    .ovf  (ar_v)
  );

  int_alu_unary #(.W(W)) u_unary (
    .op  (op),
    .src (in_src),
    .dst (in_dst),
    .res (un_res)
  );

  always_comb begin
    raw     = use_arith ? ar_res : un_res;
    aligned = raw << sh;
    r_n     = aligned[W-1];
    r_z     = (aligned == '0);
    merged  = (in_dst & ~mask) | (raw & mask);
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  int_alu_ccr u_ccr (
    .clk    (clk),
    .rst_n  (rst_n),
    .upd    (take),
    .cls    (fcls),
    .r_n    (r_n),
    .r_z    (r_z),
    .r_v    (ar_v),
    .r_c    (ar_c),
    .ld_val (in_src[FLAG_W-1:0]),
    .q      (cc_flags)
  );

  // output stage
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_wr     <= 1'b0;
    end else if (take) begin
      out_valid  <= 1'b1;
      out_result <= wr ? merged : in_dst;
      out_wr     <= wr;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/int_alu_cc_chk.sv
module int_alu_cc_chk
  import int_alu_pkg::*;
#(
  parameter int W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [4:0]        in_op,
  input logic [W-1:0]      in_src,
  input logic              out_valid,
  input logic              out_ready,
  input logic [W-1:0]      out_result,
  input logic              out_wr,
  input logic [FLAG_W-1:0] cc_flags
);
  logic acc;
  assign acc = in_valid && in_ready;

  AST_RESET_STATE: assert property (@(posedge clk) !rst_n |=> (cc_flags == '0) && !out_valid); // R1

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_wr)); // R2

  AST_TAKE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid); // R2

  AST_CLEAR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op == OP_CLR |=> cc_flags[3:0] == 4'b0100 && cc_flags[FX] == $past(cc_flags[FX])); // R7

  AST_LOGIC_X: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (in_op == OP_AND || in_op == OP_OR || in_op == OP_XOR || in_op == OP_NOT || in_op == OP_TST)
    |=> cc_flags[FX] == $past(cc_flags[FX]) && cc_flags[1:0] == 2'b00); // R6

  AST_CMP_NOWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op == OP_CMP |=> !out_wr && cc_flags[FX] == $past(cc_flags[FX])); // R8

  AST_ADDR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (in_op == OP_ADDA || in_op == OP_SUBA) |=> $stable(cc_flags) && out_wr); // R11

  AST_LOAD_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op == OP_LDCC |=> cc_flags == $past(in_src[FLAG_W-1:0]) && !out_wr); // R12

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(cc_flags)); // R13
endmodule

bind int_alu_cc int_alu_cc_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_op      (in_op),
  .in_src     (in_src),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_result (out_result),
  .out_wr     (out_wr),
  .cc_flags   (cc_flags)
);

// File: tb/int_alu_cc_tb.sv
module int_alu_cc_tb;
  import int_alu_pkg::*;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0;
  logic        in_ready;
  logic [4:0]  in_op = 0;
  logic [1:0]  in_size = 0;
  logic [31:0] in_src = 0, in_dst = 0;
  logic        out_valid;
  logic        out_ready = 1;
  logic [31:0] out_result;
  logic        out_wr;
  logic [4:0]  cc_flags;

  typedef struct {
    logic [31:0] res;
    logic        wr;
    logic [4:0]  fl;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0, n_fail = 0, cyc = 0;
  logic [4:0] mfl = 0; // model flags {X,N,Z,V,C}

  always #4 clk = ~clk; // 125 MHz

  int_alu_cc u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_size(in_size), .in_src(in_src), .in_dst(in_dst),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_wr(out_wr), .cc_flags(cc_flags)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // independent wide-integer reference
  function automatic void model(input logic [4:0] op, input logic [1:0] sz,
                                input logic [31:0] s, input logic [31:0] d,
                                output logic [31:0] res, output logic wr);
    int w;
    longint m, a, b, t, r;
    logic x, n, z, v, c;
    w = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
    m = (longint'(1) << w) - 1;
    a = longint'(d) & m;
    b = longint'(s) & m;
    x = mfl[4];
    res = d; wr = 1'b1;
    case (op)
      OP_ADD, OP_ADDX, OP_SUB, OP_SUBX, OP_NEG, OP_NEGX, OP_CMP: begin
        if (op == OP_NEG || op == OP_NEGX) begin b = a; a = 0; end
        if (op == OP_ADD)       t = a + b;
        else if (op == OP_ADDX) t = a + b + longint'(x);
        else if (op == OP_SUBX || op == OP_NEGX) t = a - b - longint'(x);
        else                    t = a - b;
        r = t & m;
        if (op == OP_ADD || op == OP_ADDX) begin
          c = ((t >> w) & 1) != 0;
          v = ((((a ^ r) & (b ^ r)) >> (w - 1)) & 1) != 0;
        end else begin
          c = t < 0;
          v = ((((a ^ b) & (a ^ r)) >> (w - 1)) & 1) != 0;
        end
        n = ((r >> (w - 1)) & 1) != 0;
        z = (r == 0);
        if (op == OP_ADDX || op == OP_SUBX || op == OP_NEGX) z = mfl[2] & z;
        if (op == OP_CMP) begin
          wr = 1'b0;
          mfl = {mfl[4], n, z, v, c};
        end else begin
          res = (d & ~32'(m)) | 32'(r);
          mfl = {c, n, z, v, c};
        end
      end
      OP_AND, OP_OR, OP_XOR, OP_NOT, OP_TST, OP_CLR: begin
        case (op)
          OP_AND:  r = a & b;
          OP_OR:   r = a | b;
          OP_XOR:  r = a ^ b;
          OP_NOT:  r = ~a & m;
          OP_CLR:  r = 0;
          default: r = a;
        endcase
        if (op == OP_TST) wr = 1'b0;
        else res = (d & ~32'(m)) | 32'(r);
        mfl = {mfl[4], ((r >> (w - 1)) & 1) != 0, r == 0, 1'b0, 1'b0};
      end
      OP_EXTBW, OP_EXTWL, OP_EXTBL, OP_SWAP, OP_MOVQ: begin
        case (op)
          OP_EXTBW: res = {d[31:16], 16'($signed(d[7:0]))};
          OP_EXTWL: res = 32'($signed(d[15:0]));
          OP_EXTBL: res = 32'($signed(d[7:0]));
          OP_SWAP:  res = {d[15:0], d[31:16]};
          default:  res = 32'($signed(s[7:0]));
        endcase
        if (op == OP_EXTBW) mfl = {mfl[4], res[15], res[15:0] == 0, 2'b00};
        else                mfl = {mfl[4], res[31], res == 0, 2'b00};
      end
      OP_ADDA: res = d + s;
      OP_SUBA: res = d - s;
      OP_LDCC: begin wr = 1'b0; mfl = s[4:0]; end
      default: wr = 1'b0;
    endcase
  endfunction

  task automatic send(input logic [4:0] op, input logic [1:0] sz,
                      input logic [31:0] s, input logic [31:0] d, input string tag);
    exp_t e;
    @(posedge clk); #1;
    in_valid = 1; in_op = op; in_size = sz; in_src = s; in_dst = d;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    model(op, sz, s, d, e.res, e.wr);
    e.fl = mfl; e.tag = tag;
    exp_q.push_back(e);
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  // fixed back-pressure pattern
  initial forever begin
    @(posedge clk); #1;
    cyc++;
    out_ready = (cyc % 5) != 3 && (cyc % 7) != 2;
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid && !out_ready)
        check(in_ready == 1'b0, "R2 stall in_ready", 64'(in_ready), 64'd0);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected result", 64'(out_result), 64'd0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(out_result == e.res && out_wr == e.wr && cc_flags == e.fl, e.tag,
                {26'd0, out_wr, cc_flags, out_result}, {26'd0, e.wr, e.fl, e.res});
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 0 && cc_flags == 0, "R1 reset state", {59'd0, cc_flags}, 64'd0);
    @(posedge clk); #1 rst_n = 1;

    send(OP_ADD,  2'b00, 32'h0000_0001, 32'hABCD_127F, "R3 byte add overflow");
    send(OP_ADD,  2'b10, 32'h0000_0001, 32'hFFFF_FFFF, "R3 long add carry zero");
    send(OP_SUB,  2'b01, 32'h0000_0002, 32'h5555_0001, "R3 word sub borrow");
    send(OP_SUB,  2'b10, 32'h0000_0001, 32'h8000_0000, "R3 long sub overflow");
    send(OP_LDCC, 2'b10, 32'h0000_0014, 32'h1234_5678, "R12 load X and Z");
    send(OP_ADDX, 2'b10, 32'hFFFF_FFFF, 32'h0000_0000, "R4 addx zero keeps Z");
    send(OP_ADDX, 2'b10, 32'h0000_0001, 32'h0000_0002, "R4 addx with X nonzero");
    send(OP_SUBX, 2'b00, 32'h0000_0010, 32'h0000_0010, "R4 subx no borrow");
    send(OP_LDCC, 2'b10, 32'h0000_0010, 32'h0, "R12 load X only");
    send(OP_SUBX, 2'b00, 32'h0000_0000, 32'h0000_0000, "R4 subx borrow from X");
    send(OP_NEG,  2'b00, 32'h0, 32'h0000_0080, "R5 neg byte min");
    send(OP_NEG,  2'b10, 32'h0, 32'h0000_0000, "R5 neg zero");
    send(OP_NEGX, 2'b01, 32'h0, 32'h0000_0005, "R5 negx word");
    send(OP_AND,  2'b01, 32'h0000_8F00, 32'hFFFF_F0F0, "R6 and word negative");
    send(OP_OR,   2'b00, 32'h0, 32'hAAAA_AA00, "R6 or byte zero");
    send(OP_XOR,  2'b10, 32'hFFFF_FFFF, 32'h0F0F_0F0F, "R6 xor long");
    send(OP_NOT,  2'b00, 32'h0, 32'h1234_56FF, "R6 not byte");
    send(OP_TST,  2'b10, 32'h0, 32'h8000_0000, "R6 test long");
    send(OP_MOVQ, 2'b00, 32'h0000_00FE, 32'h1111_1111, "R6 move quick");
    send(OP_LDCC, 2'b10, 32'h0000_001F, 32'h0, "R12 load all");
    send(OP_CLR,  2'b01, 32'h0, 32'hDEAD_BEEF, "R7 clear word");
    send(OP_CMP,  2'b10, 32'h0000_0005, 32'h0000_0005, "R8 compare equal");
    send(OP_CMP,  2'b00, 32'h0000_0001, 32'h0000_0080, "R8 compare byte overflow");
    send(OP_EXTBW, 2'b00, 32'h0, 32'h1234_0080, "R9 ext byte to word");
    send(OP_EXTWL, 2'b00, 32'h0, 32'h1234_8001, "R9 ext word to long");
    send(OP_EXTBL, 2'b01, 32'h0, 32'hFFFF_FF00, "R9 ext byte to long zero");
    send(OP_SWAP, 2'b00, 32'h0, 32'h1234_ABCD, "R10 swap");
    send(OP_LDCC, 2'b10, 32'h0000_000B, 32'h0, "R12 load mixed");
    send(OP_ADDA, 2'b00, 32'h0000_0100, 32'hFFFF_FF00, "R11 address add");
    send(OP_SUBA, 2'b01, 32'h0000_0001, 32'h0000_0000, "R11 address sub");

    while (exp_q.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
    check(cc_flags == mfl, "R13 flags hold idle", {59'd0, cc_flags}, {59'd0, mfl});
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R2 actual=%0d expected=0", exp_q.size());
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule